// File: doc/BRIEF.md
# Two-Bank DRAM Address Mapper and Access Sequencer

This block sits between a system bus and an external DRAM built from two banks, each with its own row-strobe line. The two banks sit back to back around a fixed midpoint address: the upper bank starts at the midpoint and grows upward, and the lower bank ends at the midpoint and grows downward. Software sets the size of each bank to one of four values, enables each bank separately and selects 8-bit or 16-bit organisation per bank. For an address that falls inside an enabled bank, the block splits the in-bank offset into a row and a column. It then drives a row-strobe-first access: a single beat, or a burst in which the row strobe stays low while the column strobe pulses once per beat.

Bus requests use a valid/ready handshake. The master raises `req_valid` with address, direction and burst length, and holds all of them stable until it sees `req_ready` high at a clock edge. `req_ready` is high for exactly one cycle per request. For a hit, that cycle is the final cycle of the last column-strobe pulse. For a miss (address in no enabled bank), it is the same cycle in which the request is seen, and no strobe moves. The master applies back-pressure only by leaving `req_valid` low. A built-in interval counter keeps DRAM contents alive by requesting column-before-row refresh cycles. These run only between accesses, so a burst is never broken up.

Top module: `dram_map_seq`

## Requirements
- R1: After reset both row strobes, the column strobe and the write strobe are high and `req_ready` is low. The lower bank is enabled in 8-bit mode with size code 0, the upper bank is disabled, and the refresh interval is 200 cycles.
- R2: The upper bank covers addresses MID to MID+size-1, with MID = 0x0300_0000. Its in-bank offset is address-MID, and a hit drives `dram_ras_n[1]` only.
- R3: The lower bank covers addresses MID-size to MID-1. Its in-bank offset is address-(MID-size), and a hit drives `dram_ras_n[0]` only.
- R4: Size codes 0, 1, 2 and 3 give 512 KB, 2 MB, 4 MB and 16 MB. The first address past either end of a bank misses.
- R5: In 8-bit mode the word offset equals the byte offset. In 16-bit mode it is the byte offset shifted right by one. The column is word offset bits [9:0] and the row is bits [23:10].
- R6: On a hit, the selected row strobe goes low with the row on `dram_ma` for 2 cycles before the column strobe falls. The column strobe is then low for 1 cycle per beat with the column on `dram_ma`. `dram_we_n` is low at each column pulse of a write and high for a read.
- R7: A request with `req_len`=n makes n+1 column pulses, separated by 1 high cycle, while the row strobe stays low throughout. The column increments by one per beat, modulo 1024, within the same row. `req_ready` is high only in the last pulse.
- R8: After an access or a refresh, every row strobe stays high for 2 cycles before the next access or refresh can start.
- R9: A request to an address in no enabled bank gets `req_ready` in the cycle it is presented, and no strobe goes low.
- R10: A refresh drops the column strobe for 1 cycle with both row strobes high. It then drops the row strobe of every enabled bank for 3 cycles with the column strobe still low.
- R11: With a nonzero interval N, refresh cycles start every N clock cycles while the block is otherwise idle. An interval of 0 stops refresh.
- R12: A refresh that falls due during an access waits until that access completes. It starts right after the precharge, ahead of any waiting request.
- R13: A configuration write with `cfg_sel`=0 loads the bank fields from `cfg_wdata`: enables in [1:0] (bit 0 lower, bit 1 upper), 16-bit flags in [3:2], lower size code in [5:4] and upper size code in [7:6]. With `cfg_sel`=1 it loads the refresh interval from `cfg_wdata[11:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: bank fields, 1: refresh interval |
| cfg_wdata | input | 12 | Configuration write data |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Request completed this cycle |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_len | input | 4 | Burst beats minus one |
| dram_ras_n | output | 2 | Row strobes, bit 0 lower bank, bit 1 upper bank |
| dram_cas_n | output | 1 | Column strobe |
| dram_we_n | output | 1 | Write strobe |
| dram_ma | output | 14 | Multiplexed row/column address |

## Verification
The bound checker watches strobe ordering on every cycle. It checks that a column pulse of an access is always preceded by a low row strobe and that only one bank is strobed outside refresh. It also checks that the row strobe holds between burst beats, that a refresh always drops the column strobe first, and that a miss completes with every strobe quiet. Only the directed scenarios can show the address arithmetic. That covers the bank edges for each size code, the 16-bit halving, column wrap inside a burst, the exact refresh period, and the point where a deferred refresh finally runs.

// File: rtl/dram_map_pkg.sv
package dram_map_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ROW,
    SQ_COLP,
    SQ_COLGAP,
    SQ_PRECH,
    SQ_RF_CAS,
    SQ_RF_RAS
  } seq_state_t;

  // field order sets the cfg_wdata bit positions: enables in the low bits
  typedef struct packed {
    logic [1:0] size_hi;
    logic [1:0] size_lo;
    logic [1:0] wide;
    logic [1:0] en;
  } bank_cfg_t;

  localparam bank_cfg_t BANK_CFG_RESET = '{size_hi: 2'd0, size_lo: 2'd0,
                                          wide: 2'b00, en: 2'b01};

  // log2 of the bank span in bytes for each size code
  function automatic int unsigned span_lg2(input logic [1:0] code);
    case (code)
      2'd0:    return 19;
      2'd1:    return 21;
      2'd2:    return 22;
      default: return 24;
    endcase
  endfunction

endpackage

// File: rtl/dram_addr_dec.sv
module dram_addr_dec
  import dram_map_pkg::*;
#(
  parameter int              ADDR_W = 32,
  parameter logic [ADDR_W-1:0] MID  = 32'h0300_0000,
  parameter int              ROW_W  = 14,
  parameter int              COL_W  = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  bank_cfg_t         cfg,
  output logic              hit,
  output logic              bank,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);

  localparam int WORD_W = ROW_W + COL_W;

  genvar b;
  generate
    for (b = 0; b < 2; b++) begin : g_bank
      logic [1:0]        code;
      logic [ADDR_W-1:0] span;
      logic [ADDR_W-1:0] base;
      logic [ADDR_W-1:0] off;
      logic [WORD_W-1:0] word;
      logic              in_rng;
      logic              hit_b;

      assign code   = (b == 0) ? cfg.size_lo : cfg.size_hi;
      assign span   = {{(ADDR_W-1){1'b0}}, 1'b1} << span_lg2(code);
      // lower bank ends at MID, upper bank starts there
      assign base   = (b == 0) ? (MID - span) : MID;
      assign off    = addr - base;
      assign in_rng = (addr >= base) && (off < span);
      assign hit_b  = cfg.en[b] && in_rng;
      assign word   = cfg.wide[b] ? WORD_W'(off >> 1) : WORD_W'(off);
    end
  endgenerate

  assign hit  = g_bank[0].hit_b | g_bank[1].hit_b;
  assign bank = g_bank[1].hit_b;
  assign row  = bank ? g_bank[1].word[COL_W +: ROW_W] : g_bank[0].word[COL_W +: ROW_W];
  assign col  = bank ? g_bank[1].word[COL_W-1:0]      : g_bank[0].word[COL_W-1:0];

endmodule

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int REF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REF_W-1:0] interval,
  input  logic             ack,
  output logic             pend
);

  logic [REF_W-1:0] cnt;
  logic             wrap;

  assign wrap = (interval != '0) && (cnt >= interval - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (interval == '0 || wrap) cnt <= '0;
      else                        cnt <= cnt + 1'b1;
      if (wrap)     pend <= 1'b1;
      else if (ack) pend <= 1'b0;
    end
  end

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_map_pkg::*;
#(
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  parameter int MA_W   = 14,
  parameter int LEN_W  = 4,
  parameter int T_RCD  = 2,
  parameter int T_CASW = 1,
  parameter int T_CP   = 1,
  parameter int T_RP   = 2,
  parameter int T_CSR  = 1,
  parameter int T_RREF = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_acc,
  input  logic             acc_bank,
  input  logic [ROW_W-1:0] acc_row,
  input  logic [COL_W-1:0] acc_col,
  input  logic [LEN_W-1:0] acc_len,
  input  logic             acc_wr,
  input  logic             start_ref,
  input  logic [1:0]       ref_en,
  output logic [1:0]       ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [MA_W-1:0]  ma,
  output logic             acc_last,
  output logic             idle,
  output logic             in_ref
);

  localparam int T_M1  = (T_RCD > T_CASW) ? T_RCD : T_CASW;
  localparam int T_M2  = (T_CP > T_RP) ? T_CP : T_RP;
  localparam int T_M3  = (T_CSR > T_RREF) ? T_CSR : T_RREF;
  localparam int T_M12 = (T_M1 > T_M2) ? T_M1 : T_M2;
  localparam int T_MAX = (T_M12 > T_M3) ? T_M12 : T_M3;
  localparam int TW    = (T_MAX < 2) ? 1 : $clog2(T_MAX);

  seq_state_t       st;
  logic [TW-1:0]    cnt;
  logic             bank_q;
  logic             wr_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [LEN_W-1:0] beats_q;
  logic             cnt_end;

  assign cnt_end = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      cnt     <= '0;
      bank_q  <= 1'b0;
      wr_q    <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      beats_q <= '0;
    end else begin
      case (st)
        SQ_IDLE: begin
          if (start_ref) begin
            st  <= SQ_RF_CAS;
            cnt <= TW'(T_CSR - 1);
          end else if (start_acc) begin
            st      <= SQ_ROW;
            cnt     <= TW'(T_RCD - 1);
            bank_q  <= acc_bank;
            wr_q    <= acc_wr;
            row_q   <= acc_row;
            col_q   <= acc_col;
            beats_q <= acc_len;
          end
        end
        SQ_ROW: begin
          if (cnt_end) begin
            st  <= SQ_COLP;
            cnt <= TW'(T_CASW - 1);
          end else cnt <= cnt - 1'b1;
        end
        SQ_COLP: begin
          if (cnt_end) begin
            if (beats_q == '0) begin
              st  <= SQ_PRECH;
              cnt <= TW'(T_RP - 1);
            end else begin
              st      <= SQ_COLGAP;
              cnt     <= TW'(T_CP - 1);
              beats_q <= beats_q - 1'b1;
              col_q   <= col_q + 1'b1;
            end
          end else cnt <= cnt - 1'b1;
        end
        SQ_COLGAP: begin
          if (cnt_end) begin
            st  <= SQ_COLP;
            cnt <= TW'(T_CASW - 1);
          end else cnt <= cnt - 1'b1;
        end
        SQ_RF_CAS: begin
          if (cnt_end) begin
            st  <= SQ_RF_RAS;
            cnt <= TW'(T_RREF - 1);
          end else cnt <= cnt - 1'b1;
        end
        SQ_RF_RAS: begin
          if (cnt_end) begin
            st  <= SQ_PRECH;
            cnt <= TW'(T_RP - 1);
          end else cnt <= cnt - 1'b1;
        end
        SQ_PRECH: begin
          if (cnt_end) st <= SQ_IDLE;
          else         cnt <= cnt - 1'b1;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    ras_n = 2'b11;
    cas_n = 1'b1;
    we_n  = 1'b1;
    ma    = '0;
    case (st)
      SQ_ROW: begin
        ras_n[bank_q] = 1'b0;
        ma            = MA_W'(row_q);
      end
      SQ_COLP: begin
        ras_n[bank_q] = 1'b0;
        cas_n         = 1'b0;
        we_n          = !wr_q;
        ma            = MA_W'(col_q);
      end
      SQ_COLGAP: begin
        ras_n[bank_q] = 1'b0;
        we_n          = !wr_q;
        ma            = MA_W'(col_q);
      end
      SQ_RF_CAS: cas_n = 1'b0;
      SQ_RF_RAS: begin
        cas_n = 1'b0;
        ras_n = ~ref_en;
      end
      default: ;
    endcase
  end

  assign acc_last = (st == SQ_COLP) && cnt_end && (beats_q == '0);
  assign idle     = (st == SQ_IDLE);
  assign in_ref   = (st == SQ_RF_CAS) || (st == SQ_RF_RAS);

endmodule

// File: rtl/dram_map_seq.sv
module dram_map_seq
  import dram_map_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] MID       = 32'h0300_0000,
  parameter int                ROW_W     = 14,
  parameter int                COL_W     = 10,
  parameter int                LEN_W     = 4,
  parameter int                REF_W     = 12,
  parameter int                REF_RESET = 200,
  parameter int                T_RCD     = 2,
  parameter int                T_CASW    = 1,
  parameter int                T_CP      = 1,
  parameter int                T_RP      = 2,
  parameter int                T_CSR     = 1,
  parameter int                T_RREF    = 3,
  localparam int               MA_W      = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int               CFG_W     = (REF_W > 8) ? REF_W : 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [LEN_W-1:0]  req_len,
  output logic [1:0]        dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic [MA_W-1:0]   dram_ma
);

  bank_cfg_t        cfg_q;
  logic [REF_W-1:0] ival_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= BANK_CFG_RESET;
      ival_q <= REF_W'(REF_RESET);
    end else if (cfg_we) begin
      if (!cfg_sel) cfg_q  <= bank_cfg_t'(cfg_wdata[7:0]);
      else          ival_q <= cfg_wdata[REF_W-1:0];
    end
  end

  logic             dec_hit;
  logic             dec_bank;
  logic [ROW_W-1:0] dec_row;
  logic [COL_W-1:0] dec_col;

  dram_addr_dec #(
    .ADDR_W(ADDR_W), .MID(MID), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_dec (
    .addr(req_addr), .cfg(cfg_q), .hit(dec_hit), .bank(dec_bank),
    .row(dec_row), .col(dec_col)
  );

  logic ref_pend;
  logic seq_idle;
  logic seq_last;
  logic seq_in_ref;
  logic start_ref;
  logic start_acc;
  logic go;

  assign start_ref = seq_idle && ref_pend;
  assign go        = seq_idle && !ref_pend && req_valid;
  assign start_acc = go && dec_hit;
  assign req_ready = (go && !dec_hit) || seq_last;

  dram_ref_timer #(.REF_W(REF_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .interval(ival_q), .ack(start_ref), .pend(ref_pend)
  );

  dram_seq_fsm #(
    .ROW_W(ROW_W), .COL_W(COL_W), .MA_W(MA_W), .LEN_W(LEN_W),
    .T_RCD(T_RCD), .T_CASW(T_CASW), .T_CP(T_CP), .T_RP(T_RP),
    .T_CSR(T_CSR), .T_RREF(T_RREF)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_acc(start_acc), .acc_bank(dec_bank), .acc_row(dec_row),
    .acc_col(dec_col), .acc_len(req_len), .acc_wr(req_write),
    .start_ref(start_ref), .ref_en(cfg_q.en),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n), .ma(dram_ma),
    .acc_last(seq_last), .idle(seq_idle), .in_ref(seq_in_ref)
  );

endmodule

// File: rtl/dram_map_seq_chk.sv
module dram_map_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] ras_n,
  input logic       cas_n,
  input logic       in_ref
);

  // R9: completion only answers a live request
  p_ready_has_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);

  // R9: a completion outside a column pulse is a miss with every row strobe high
  p_miss_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && cas_n) |-> (ras_n == 2'b11));

  // R2 / R3: outside refresh pulses only one bank is strobed
  p_one_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cas_n |-> ($countones(~ras_n) <= 1));

  // R6: an access column pulse follows a row strobe already low
  p_row_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !in_ref) |-> ($past(ras_n) != 2'b11));

  // R10: refresh opens with column strobe while rows are idle
  p_cbr_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && in_ref) |-> (ras_n == 2'b11));

  // R7: between beats of a burst the row strobe does not move
  p_burst_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cas_n) && !in_ref && !$past(in_ref) && !$past(req_ready)) |-> $stable(ras_n));

  genvar b;
  generate
    for (b = 0; b < 2; b++) begin : g_bk
      // R10: a row strobe falling under a low column strobe was preceded by it
      p_cbr_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n[b]) && !cas_n) |-> !$past(cas_n));

      // R8: a released row strobe stays high at least one more cycle
      p_precharge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n[b]) |=> ras_n[b]);
    end
  endgenerate

endmodule

bind dram_map_seq dram_map_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .ras_n(dram_ras_n), .cas_n(dram_cas_n), .in_ref(seq_in_ref)
);

// File: tb/dram_map_seq_tb_top.sv
`timescale 1ns/1ps
module dram_map_seq_tb_top;

  localparam logic [31:0] MID   = 32'h0300_0000;
  localparam int          T_RCD = 2;
  localparam int          T_RP  = 2;
  localparam int          T_RREF = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [11:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [3:0]  req_len = '0;
  logic [1:0]  dram_ras_n;
  logic        dram_cas_n;
  logic        dram_we_n;
  logic [13:0] dram_ma;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int cyc = 0;
  int acc_cbr = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_map_seq #(.MID(MID)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_len(req_len),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_ma(dram_ma)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic cfg_write(input bit sel, input logic [11:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [11:0] bank_word(input logic [1:0] en, input logic [1:0] wide,
                                            input logic [1:0] s_lo, input logic [1:0] s_hi);
    return {4'h0, s_hi, s_lo, wide, en};
  endfunction

  function automatic logic [31:0] span_of(input int code);
    case (code)
      0: return 32'h0008_0000;
      1: return 32'h0020_0000;
      2: return 32'h0040_0000;
      default: return 32'h0100_0000;
    endcase
  endfunction

  // drives one request and checks strobes, address and completion
  task automatic do_access(input logic [31:0] a, input bit wr, input int len,
                           input bit exp_hit, input int eb, input logic [31:0] off,
                           input bit wide, input string rq);
    logic [31:0] word;
    logic [13:0] erow;
    logic [9:0]  ecol;
    bit started = 0, got = 0, prev_cas;
    int rcd = 0, beats = 0, rowbad = 0, colbad = 0, webad = 0, drop = 0, other = 0, quiet = 0;
    logic rdy_cas = 1'b1;
    word = wide ? (off >> 1) : off;
    erow = word[23:10];
    ecol = word[9:0];
    acc_cbr = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_len = 4'(len);
    prev_cas = 1'b1;
    for (int k = 0; k < 400 && !got; k++) begin
      #1;
      if (!exp_hit && (dram_ras_n != 2'b11 || !dram_cas_n)) quiet++;
      if (exp_hit && !started && dram_ras_n[eb] == 1'b0 && dram_cas_n) started = 1;
      if (started) begin
        if (dram_ras_n[1-eb] == 1'b0) other++;
        if (dram_ras_n[eb] != 1'b0) drop++;
        if (dram_cas_n && beats == 0) begin
          rcd++;
          if (dram_ma != erow) rowbad++;
        end
        if (!dram_cas_n && prev_cas) begin
          if (dram_ma != 14'(10'(ecol + 10'(beats)))) colbad++;
          if (dram_we_n != !wr) webad++;
          beats++;
        end
        if (!dram_cas_n && prev_cas && dram_ras_n == 2'b11) acc_cbr++;
      end
      prev_cas = dram_cas_n;
      if (req_ready) begin
        got = 1;
        rdy_cas = dram_cas_n;
      end else @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(got, rq, "request completed", got, 1);
    if (!exp_hit) begin
      chk(quiet == 0, rq, "miss moved a strobe", quiet, 0);
      chk(!started, rq, "miss started", started, 0);
    end else begin
      chk(started, rq, "row strobe of expected bank", started, 1);
      chk(rcd == T_RCD, "R6", "row lead cycles", rcd, T_RCD);
      chk(rowbad == 0, rq, "row address", rowbad, 0);
      chk(colbad == 0, rq, "column address per beat", colbad, 0);
      chk(webad == 0, "R6", "write strobe", webad, 0);
      chk(beats == len + 1, "R7", "beat count", beats, len + 1);
      chk(drop == 0, "R7", "row strobe held in burst", drop, 0);
      chk(other == 0, rq, "other bank quiet", other, 0);
      chk(rdy_cas == 1'b0, "R7", "ready in last pulse", rdy_cas, 0);
      chk(acc_cbr == 0, "R12", "no refresh inside access", acc_cbr, 0);
      for (int p = 0; p < T_RP; p++) begin
        #1;
        chk(dram_ras_n == 2'b11, "R8", "precharge row strobes high", dram_ras_n, 3);
        @(negedge clk);
      end
    end
  endtask

  // waits for the column strobe to fall with both row strobes high
  task automatic wait_cbr(input int limit, output bit found, output int at);
    bit prev;
    found = 0; at = 0;
    #1;
    prev = dram_cas_n;
    for (int k = 0; k < limit && !found; k++) begin
      @(negedge clk); #1;
      if (!dram_cas_n && prev && dram_ras_n == 2'b11) begin
        found = 1; at = cyc;
      end
      prev = dram_cas_n;
    end
  endtask

  task automatic t_reset();
    #1;
    chk(dram_ras_n == 2'b11, "R1", "reset row strobes", dram_ras_n, 3);
    chk(dram_cas_n == 1'b1, "R1", "reset column strobe", dram_cas_n, 1);
    chk(dram_we_n == 1'b1, "R1", "reset write strobe", dram_we_n, 1);
    chk(req_ready == 1'b0, "R1", "reset ready", req_ready, 0);
    do_access(MID - 32'h10, 1'b0, 0, 1, 0, 32'h0008_0000 - 32'h10, 0, "R1");
    do_access(MID - 32'h0008_0001, 1'b0, 0, 0, 0, 0, 0, "R1");
    do_access(MID + 32'h20, 1'b0, 0, 0, 0, 0, 0, "R1");
  endtask

  task automatic t_sizes();
    for (int c = 0; c < 4; c++) begin
      logic [31:0] sp;
      sp = span_of(c);
      cfg_write(0, bank_word(2'b11, 2'b00, 2'(c), 2'(c)));
      do_access(MID + sp - 1, 1'b0, 0, 1, 1, sp - 1, 0, "R2");
      do_access(MID + sp, 1'b0, 0, 0, 0, 0, 0, "R4");
      do_access(MID - sp, 1'b1, 0, 1, 0, 32'h0, 0, "R3");
      do_access(MID - sp - 1, 1'b0, 0, 0, 0, 0, 0, "R4");
      do_access(MID - 1, 1'b0, 0, 1, 0, sp - 1, 0, "R3");
    end
  endtask

  task automatic t_width();
    cfg_write(0, bank_word(2'b11, 2'b11, 2'd2, 2'd3));
    do_access(MID + 32'h0012_3456, 1'b0, 0, 1, 1, 32'h0012_3456, 1, "R5");
    do_access(MID - 32'h0000_2002, 1'b1, 0, 1, 0, 32'h0040_0000 - 32'h2002, 1, "R5");
    cfg_write(0, bank_word(2'b11, 2'b01, 2'd2, 2'd3));
    do_access(MID + 32'h0012_3456, 1'b0, 0, 1, 1, 32'h0012_3456, 0, "R13");
  endtask

  task automatic t_disabled();
    cfg_write(0, bank_word(2'b10, 2'b00, 2'd0, 2'd0));
    do_access(MID - 32'h4, 1'b0, 0, 0, 0, 0, 0, "R9");
    do_access(MID + 32'h4, 1'b0, 0, 1, 1, 32'h4, 0, "R13");
    cfg_write(0, bank_word(2'b00, 2'b00, 2'd0, 2'd0));
    do_access(MID + 32'h4, 1'b1, 3, 0, 0, 0, 0, "R9");
  endtask

  task automatic t_burst();
    cfg_write(0, bank_word(2'b11, 2'b00, 2'd1, 2'd1));
    do_access(MID + 32'h7FE, 1'b1, 3, 1, 1, 32'h7FE, 0, "R7");
    do_access(MID - 32'h100, 1'b0, 7, 1, 0, 32'h0020_0000 - 32'h100, 0, "R7");
  endtask

  task automatic t_refresh();
    bit f1, f2;
    int a1, a2;
    cfg_write(0, bank_word(2'b11, 2'b00, 2'd0, 2'd0));
    cfg_write(1, 12'd20);
    wait_cbr(100, f1, a1);
    chk(f1, "R10", "refresh seen", f1, 1);
    for (int k = 0; k < T_RREF; k++) begin
      @(negedge clk); #1;
      chk(dram_ras_n == 2'b00 && !dram_cas_n, "R10", "rows low under column",
          {dram_ras_n, dram_cas_n}, 0);
    end
    @(negedge clk); #1;
    chk(dram_ras_n == 2'b11 && dram_cas_n, "R10", "refresh released",
        {dram_ras_n, dram_cas_n}, 7);
    wait_cbr(100, f2, a2);
    chk(f2 && (a2 - a1 == 20), "R11", "refresh period", a2 - a1, 20);
  endtask

  task automatic t_ref_off();
    bit f;
    int a;
    cfg_write(1, 12'd0);
    repeat (12) @(negedge clk);
    wait_cbr(300, f, a);
    chk(!f, "R11", "zero interval stops refresh", f, 0);
  endtask

  task automatic t_defer();
    bit f;
    int a, r_at;
    cfg_write(0, bank_word(2'b11, 2'b00, 2'd3, 2'd3));
    cfg_write(1, 12'd10);
    wait_cbr(100, f, a);
    do_access(MID + 32'h100, 1'b0, 15, 1, 1, 32'h100, 0, "R12");
    r_at = cyc;
    wait_cbr(T_RP + 4, f, a);
    chk(f, "R12", "deferred refresh runs after burst", f, 1);
    chk(a - r_at <= 2, "R12", "deferred refresh start", a - r_at, 2);
    cfg_write(1, 12'd0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    cfg_write(1, 12'd0);
    t_sizes();
    t_width();
    t_disabled();
    t_burst();
    t_refresh();
    t_ref_off();
    t_defer();
    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

endmodule